// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the device end of a 256-byte serial memory on a two-wire bus. It synchronises and oversamples the clock and data lines with the system clock and detects START and STOP from them. It recognises its own 7-bit device address and takes a word address, then data bytes. Incoming data bytes collect in a four-byte page buffer. A STOP that follows at least one data byte writes the buffered bytes into the internal register array and starts a timed internal write cycle. The bus is ignored for the whole of that cycle.

A host waits for the end of a write by polling. It sends START and the device address again and again until the device acknowledges. Reads start from the internal address counter. That counter may be left by an earlier access, or set by a write header that carries only a word address, followed by a repeated START. Reads go on byte after byte for as long as the host acknowledges. The block has one output, a pull-down request for the data line. The pad and the wired-AND bus sit outside the block.

Top module: `twi_eeprom_slave`

## Requirements
- R1: Byte fields go MSB first. Data is sampled on the rising clock edge. In the first byte after START, bits 7:1 are the device address and bit 0 selects the direction (1 = read). The block pulls the data line low in the ninth clock only when bits 7:1 equal DEV_ADDR. For any other address it gives no acknowledge and stays silent until the next START or STOP.
- R2: In a write transfer, the word-address byte and every data byte are acknowledged by pulling the data line low during the ninth clock.
- R3: Each data byte is stored at the current address. Only the two low address bits then increment. The upper six bits stay fixed, so a page is the four bytes sharing those bits.
- R4: When more than four data bytes arrive before STOP, the in-page address wraps. Later bytes overwrite earlier ones in the same page.
- R5: The buffered bytes reach the array only on STOP. That STOP starts an internal write cycle of WRITE_TICKS clock ticks. A STOP with no data byte since the last START starts no cycle.
- R6: During the internal write cycle every bus event is ignored, including START and the device address. No acknowledge is given, and a write attempted in that time changes no byte.
- R7: After reset all bytes and the address counter are zero. The counter holds the last accessed address plus one, so a read without a word address continues from there. After a page write this is the in-page wrapped value.
- R8: A write header carrying only a word address, followed by a repeated START and a read address, returns the byte at that word address.
- R9: While the host acknowledges read bytes, the block sends the next byte. The address increments over the full 8 bits and wraps from 0xFF to 0x00.
- R10: If the host does not acknowledge a read byte (data line high in the ninth clock), the block stops sending. It leaves the line released until STOP or START, so further clocks read as all ones.
- R11: The data line is released out of reset and whenever the block is neither acknowledging nor sending. It changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
The assertions assume a host that moves the data line only while the bus clock is low. Each change must come a few system clocks after the falling edge, so that the synchroniser sees the clock low first and no false START or STOP appears. They also assume the bus clock stays high or low much longer than the synchroniser delay. The bench host builds every bit from half-periods of ten system clocks, with data changes placed mid-low. It makes START and STOP only with the clock held high, so its constrained-random page writes and reads stay inside these limits.

// File: rtl/twe_pkg.sv
package twe_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADDR,
        S_WADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK,
        S_WAIT,
        S_BUSY
    } state_e;
endpackage

// File: rtl/twe_bus_sync.sv
// Two-flop synchroniser for both bus lines plus edge, START and STOP detection.
// STAGES must be at least 2.
module twe_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_p_q  <= scl_sh_q[STAGES-1];
            sda_p_q  <= sda_sh_q[STAGES-1];
        end
    end

    assign scl_o      = scl_sh_q[STAGES-1];
    assign sda_o      = sda_sh_q[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_p_q;
    assign scl_fall_o = ~scl_o & scl_p_q;
    assign start_o    = scl_o & scl_p_q & sda_p_q & ~sda_o;
    assign stop_o     = scl_o & scl_p_q & ~sda_p_q & sda_o;
endmodule

// File: rtl/twe_page_buf.sv
// One lane per byte of a page; valid bits mark the lanes written since START.
module twe_page_buf #(
    parameter int PB = 2,
    parameter int DW = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         wr_i,
    input  logic [PB-1:0]                idx_i,
    input  logic [DW-1:0]                data_i,
    output logic [(1<<PB)-1:0][DW-1:0]   lane_o,
    output logic [(1<<PB)-1:0]           valid_o
);
    localparam int LANES = 1 << PB;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DW-1:0] data_q;
        logic          vld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q <= '0;
                vld_q  <= 1'b0;
            end else if (clr_i) begin
                vld_q  <= 1'b0;
            end else if (wr_i && idx_i == PB'(g)) begin
                data_q <= data_i;
                vld_q  <= 1'b1;
            end
        end
        assign lane_o[g]  = data_q;
        assign valid_o[g] = vld_q;
    end

    // A written lane is marked for the commit (R3)
    p_lane_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> valid_o[$past(idx_i)]);
endmodule

// File: rtl/twe_mem.sv
// Register-array storage with a combinational read port and a page-wide commit port.
module twe_mem #(
    parameter int AW = 8,
    parameter int PB = 2,
    parameter int DW = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [AW-1:0]               rd_addr_i,
    output logic [DW-1:0]               rd_data_o,
    input  logic                        commit_i,
    input  logic [AW-PB-1:0]            page_i,
    input  logic [(1<<PB)-1:0][DW-1:0]  lane_i,
    input  logic [(1<<PB)-1:0]          valid_i
);
    localparam int DEPTH = 1 << AW;
    localparam int LANES = 1 << PB;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (valid_i[l]) mem_q[{page_i, PB'(l)}] <= lane_i[l];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         AW          = 8,
    parameter int         PB          = 2,
    parameter int         WRITE_TICKS = 500000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    import twe_pkg::*;

    localparam int DW    = 8;
    localparam int LANES = 1 << PB;
    localparam int CNT_W = $clog2(WRITE_TICKS + 1);
    localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(WRITE_TICKS - 1);

    typedef struct packed {
        state_e            st;
        logic [3:0]        bit_cnt;
        logic [DW-1:0]     sh;
        logic [AW-1:0]     addr;
        logic              rw;
        logic              pull;
        logic              mack;
        logic              have_data;
        logic [CNT_W-1:0]  tick;
    } regs_t;

    regs_t q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
    logic buf_clr, buf_wr, commit;
    logic [PB-1:0] buf_idx;
    logic [LANES-1:0][DW-1:0] lane;
    logic [LANES-1:0] lane_vld;
    logic [DW-1:0] rd_data;

    twe_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop)
    );

    twe_page_buf #(.PB(PB), .DW(DW)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (buf_clr),
        .wr_i    (buf_wr),
        .idx_i   (buf_idx),
        .data_i  (q.sh),
        .lane_o  (lane),
        .valid_o (lane_vld)
    );

    twe_mem #(.AW(AW), .PB(PB), .DW(DW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (q.addr),
        .rd_data_o (rd_data),
        .commit_i  (commit),
        .page_i    (q.addr[AW-1:PB]),
        .lane_i    (lane),
        .valid_i   (lane_vld)
    );

    assign buf_idx = q.addr[PB-1:0];

    always_comb begin
        n       = q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        commit  = 1'b0;
        if (q.st == S_BUSY) begin
            n.pull = 1'b0;
            if (q.tick == TICK_LAST) begin
                n.st   = S_IDLE;
                n.tick = '0;
            end else begin
                n.tick = q.tick + 1'b1;
            end
        end else if (start) begin
            n.st        = S_DEV;
            n.bit_cnt   = '0;
            n.pull      = 1'b0;
            n.have_data = 1'b0;
            buf_clr     = 1'b1;
        end else if (stop) begin
            n.pull    = 1'b0;
            n.bit_cnt = '0;
            n.tick    = '0;
            if (q.have_data) begin
                commit      = 1'b1;
                n.have_data = 1'b0;
                n.st        = S_BUSY;
            end else begin
                n.st = S_IDLE;
            end
        end else begin
            unique case (q.st)
                S_DEV, S_WADDR, S_WDATA: begin
                    if (scl_rise) begin
                        n.sh      = {q.sh[DW-2:0], sda_s};
                        n.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (scl_fall && q.bit_cnt == 4'd8) begin
                        n.bit_cnt = '0;
                        if (q.st == S_DEV) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                n.rw   = q.sh[0];
                                n.pull = 1'b1;
                                n.st   = S_DEV_ACK;
                            end else begin
                                n.st = S_WAIT;
                            end
                        end else if (q.st == S_WADDR) begin
                            n.addr = q.sh[AW-1:0];
                            n.pull = 1'b1;
                            n.st   = S_WADDR_ACK;
                        end else begin
                            buf_wr      = 1'b1;
                            n.addr      = {q.addr[AW-1:PB], q.addr[PB-1:0] + PB'(1)};
                            n.have_data = 1'b1;
                            n.pull      = 1'b1;
                            n.st        = S_WDATA_ACK;
                        end
                    end
                end
                S_DEV_ACK, S_WADDR_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        n.pull    = 1'b0;
                        n.bit_cnt = '0;
                        if (q.st == S_DEV_ACK && q.rw) begin
                            n.sh   = rd_data;
                            n.pull = ~rd_data[DW-1];
                            n.addr = q.addr + AW'(1);
                            n.st   = S_RDATA;
                        end else if (q.st == S_DEV_ACK) begin
                            n.st = S_WADDR;
                        end else begin
                            n.st = S_WDATA;
                        end
                    end
                end
                S_RDATA: begin
                    if (scl_rise) begin
                        n.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.bit_cnt == 4'd8) begin
                            n.pull    = 1'b0;
                            n.mack    = 1'b0;
                            n.bit_cnt = '0;
                            n.st      = S_RACK;
                        end else begin
                            n.sh   = {q.sh[DW-2:0], 1'b0};
                            n.pull = ~q.sh[DW-2];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        n.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            n.sh   = rd_data;
                            n.pull = ~rd_data[DW-1];
                            n.addr = q.addr + AW'(1);
                            n.st   = S_RDATA;
                        end else begin
                            n.pull = 1'b0;
                            n.st   = S_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_pull_o = q.pull;

    // Internal write cycle keeps the line released (R6)
    p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_BUSY) |-> !sda_pull_o);

    // Write cycle only begins right after a STOP (R5)
    p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == S_BUSY) |-> $past(stop));

    // Storing a data byte leaves the page bits alone (R3)
    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> $stable(q.addr[AW-1:PB]));

    // Line only moves while the bus clock is low (R11)
    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s);

    // After a host NACK the line stays released (R10)
    p_wait_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT) |-> !sda_pull_o);
endmodule

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb;
    localparam logic [6:0] DEV = 7'h50;
    localparam int WT   = 600;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic sda_bus;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] mem_m [256];
    logic [7:0] cur_m = 8'h00;
    logic [7:0] wbuf [8];

    always #5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull;

    twi_eeprom_slave #(.DEV_ADDR(DEV), .AW(8), .PB(2), .WRITE_TICKS(WT), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_n(HALF/2); m_sda = 1'b1; wait_n(HALF/2);
        scl = 1'b1; wait_n(HALF);
        m_sda = 1'b0; wait_n(HALF);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(HALF/2); m_sda = 1'b0; wait_n(HALF/2);
        scl = 1'b1; wait_n(HALF);
        m_sda = 1'b1; wait_n(HALF);
    endtask

    // Returns 1 when the device acknowledged; counts device pulls during data bits
    task automatic send_byte(input logic [7:0] b, output logic ack, output int drv);
        drv = 0;
        for (int i = 7; i >= 0; i--) begin
            wait_n(HALF/2); m_sda = b[i]; wait_n(HALF/2);
            scl = 1'b1; wait_n(HALF - 1);
            if (sda_pull) drv++;
            wait_n(1); scl = 1'b0;
        end
        wait_n(HALF/2); m_sda = 1'b1; wait_n(HALF/2);
        scl = 1'b1; wait_n(HALF - 1);
        ack = ~sda_bus;
        wait_n(1); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_n(HALF/2); m_sda = 1'b1; wait_n(HALF/2);
            scl = 1'b1; wait_n(HALF - 1);
            b[i] = sda_bus;
            wait_n(1); scl = 1'b0;
        end
        wait_n(HALF/2); m_sda = ~give_ack; wait_n(HALF/2);
        scl = 1'b1; wait_n(HALF);
        scl = 1'b0;
    endtask

    function automatic logic [7:0] page_addr(input logic [7:0] a, input int k);
        logic [1:0] lo;
        lo = a[1:0] + 2'(k);
        return {a[7:2], lo};
    endfunction

    task automatic poll_ready(input string req);
        logic ack;
        int drv;
        int tries;
        tries = 0;
        ack = 1'b0;
        while (!ack && tries < 60) begin
            bus_start();
            send_byte({DEV, 1'b0}, ack, drv);
            bus_stop();
            tries++;
        end
        chk(req, {31'd0, ack}, 32'd1);
    endtask

    task automatic do_write(input logic [7:0] a, input int n);
        logic ack;
        int drv;
        bus_start();
        send_byte({DEV, 1'b0}, ack, drv);
        chk("R1 device address ack", {31'd0, ack}, 32'd1);
        send_byte(a, ack, drv);
        chk("R2 word address ack", {31'd0, ack}, 32'd1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack, drv);
            chk("R2 data byte ack", {31'd0, ack}, 32'd1);
            chk("R11 released while host sends", drv, 0);
        end
        bus_stop();
        for (int k = 0; k < n; k++) mem_m[page_addr(a, k)] = wbuf[k];
        cur_m = page_addr(a, n);
        // first poll lands inside the write cycle
        bus_start();
        send_byte({DEV, 1'b0}, ack, drv);
        bus_stop();
        chk("R6 no ack during write cycle", {31'd0, ack}, 32'd0);
        poll_ready("R5 write cycle ends");
    endtask

    task automatic read_seq(input string req, input int n);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk(req, {24'd0, b}, {24'd0, mem_m[cur_m]});
            cur_m = cur_m + 8'd1;
        end
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, input string req);
        logic ack;
        int drv;
        bus_start();
        send_byte({DEV, 1'b0}, ack, drv);
        send_byte(a, ack, drv);
        chk("R8 dummy write address ack", {31'd0, ack}, 32'd1);
        bus_start();
        send_byte({DEV, 1'b1}, ack, drv);
        chk("R1 read address ack", {31'd0, ack}, 32'd1);
        cur_m = a;
        read_seq(req, n);
        bus_stop();
    endtask

    task automatic cur_read(input int n, input string req);
        logic ack;
        int drv;
        bus_start();
        send_byte({DEV, 1'b1}, ack, drv);
        chk("R1 read address ack", {31'd0, ack}, 32'd1);
        read_seq(req, n);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog R5: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic ack;
        int drv;
        logic [7:0] b;
        int unsigned seed_v;
        seed_v = $urandom(32'd7321);
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        wait_n(5);
        chk("R11 released in reset", {31'd0, sda_pull}, 32'd0);
        rst_n = 1'b1;
        wait_n(5);
        chk("R11 released after reset", {31'd0, sda_pull}, 32'd0);

        // R7: reset contents and counter
        cur_read(2, "R7 read after reset");

        // R1: foreign address gets no ack, line stays released
        bus_start();
        send_byte({7'h23, 1'b0}, ack, drv);
        chk("R1 foreign address nack", {31'd0, ack}, 32'd0);
        send_byte(8'h00, ack, drv);
        chk("R1 silent after mismatch", {31'd0, ack}, 32'd0);
        bus_stop();

        // R3/R4: six bytes from 0x46 wrap inside page 0x44..0x47
        for (int k = 0; k < 6; k++) wbuf[k] = 8'hA0 + 8'(k);
        do_write(8'h46, 6);
        rand_read(8'h44, 4, "R4 page wrap overwrite");
        chk("R3 neighbour page untouched", {24'd0, mem_m[8'h48]}, 32'h0);
        rand_read(8'h48, 1, "R3 neighbour page untouched");

        // R7: current read after a page write resumes at wrapped address
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(8'h1E, 3);
        cur_read(1, "R7 current read after page write");

        // R5: address-only write starts no cycle, next access acks at once
        bus_start();
        send_byte({DEV, 1'b0}, ack, drv);
        send_byte(8'h30, ack, drv);
        bus_stop();
        cur_m = 8'h30;
        bus_start();
        send_byte({DEV, 1'b0}, ack, drv);
        chk("R5 no cycle without data", {31'd0, ack}, 32'd1);
        bus_stop();

        // R6: write attempt during a write cycle is dropped
        wbuf[0] = 8'h5C;
        bus_start();
        send_byte({DEV, 1'b0}, ack, drv);
        send_byte(8'h90, ack, drv);
        send_byte(wbuf[0], ack, drv);
        bus_stop();
        mem_m[8'h90] = 8'h5C;
        bus_start();
        send_byte({DEV, 1'b0}, ack, drv);
        send_byte(8'h90, ack, drv);
        chk("R6 ignored address during cycle", {31'd0, ack}, 32'd0);
        send_byte(8'hEE, ack, drv);
        bus_stop();
        poll_ready("R6 device returns after cycle");
        rand_read(8'h90, 1, "R6 byte unchanged by dropped write");

        // R9: sequential read across the top of the array
        wbuf[0] = 8'hF1; wbuf[1] = 8'hF2;
        do_write(8'hFE, 2);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02;
        do_write(8'h00, 2);
        rand_read(8'hFE, 4, "R9 sequential wrap");

        // R10: host NACK ends output, further clocks read ones
        bus_start();
        send_byte({DEV, 1'b0}, ack, drv);
        send_byte(8'h00, ack, drv);
        bus_start();
        send_byte({DEV, 1'b1}, ack, drv);
        recv_byte(1'b0, b);
        chk("R10 byte before nack", {24'd0, b}, 32'h01);
        recv_byte(1'b0, b);
        chk("R10 released after nack", {24'd0, b}, 32'hFF);
        bus_stop();
        cur_m = 8'h01;
        cur_read(1, "R7 counter after nack read");

        // Constrained random page writes and reads
        for (int it = 0; it < 12; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(a, n);
            cur_read(1, "R7 random current read");
            rand_read(page_addr(a, 0), 1 + int'($urandom % 5), "R3 random page read");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule